// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Target

This block sits on a two-wire serial bus as a target device. It gives the bus master byte access to 96 bytes of local storage. The storage is split into a 32-byte register window and a 64-byte scratch RAM window, and the registers are held as plain storage.

The master selects the block with a fixed 7-bit code followed by a direction bit. In a write transfer, the first byte loads a word pointer and any further bytes are stored at that pointer. Reads start at the pointer. The pointer is one shared register that both directions use and that keeps its value from one transfer to the next. This gives four access forms from the same pointer: byte or burst writes, current-pointer reads, random reads (an address-only write followed by a repeated START), and sequential reads.

The clock and data lines are brought into the system clock through two-flop synchronisers. The data line is pulled low only through an open-drain enable.

Top module: `i2c_mem_target`

## Requirements
- R1: A control byte whose upper seven bits are 1101111 is acknowledged, with bit 0 selecting read (1) or write (0). Any other control byte gets no ACK, and the block ignores every following byte until the next START.
- R2: The block pulls SDA low (sda_oe_o = 1) only in the ACK slot (the ninth SCL clock) of a byte it accepts, or for a 0 bit of read data. At all other times SDA is released.
- R3: In a write transfer, the byte after the control byte is loaded into the pointer. The next byte is stored at that location, and the pointer then addresses the following location.
- R4: Each further data byte in the same write transfer is stored at the advanced pointer and acknowledged.
- R5: A read transfer that is not preceded by an address returns the byte at the current pointer.
- R6: An address-only write ended by a repeated START stores no data and keeps the loaded pointer, so the read that follows starts at that address.
- R7: In a read, a master ACK makes the block send the byte at the next location. A master NACK makes the block release SDA. After each byte is read, the pointer addresses the next location.
- R8: Pointer advance wraps inside its window: 0x1F goes to 0x00, and 0x5F goes to 0x20.
- R9: A word address of 0x60 or above is not acknowledged, and it leaves the pointer unchanged.
- R10: After reset, SDA is released and the pointer is 0x00. Stored bytes are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the data line |

## Verification
Directed transfers cover several cases:
- a wrong control code and out-of-map addresses, which show that NACK paths leave the pointer untouched;
- bursts that cross 0x1F and 0x5F, which separate wrapping inside a window from plain incrementing;
- an address-only write followed by a current read, which shows that pointer set-up and data storage are kept apart;
- a reset taken between transfers, which shows that the pointer clears while the storage keeps its contents.

Seeded random mixes of burst writes, current reads and random reads then compare every acknowledge and data byte against a reference model of the memory and pointer. Any drift between the pointer's write path and its read path shows up there.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        BK_CTRL,
        BK_ADDR,
        BK_DATA
    } kind_e;

    typedef struct packed {
        phase_e            phase;
        kind_e             kind;
        logic [3:0]        bits;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              go_tx;
        logic              more;
        logic              oe;
    } tgt_state_t;

endpackage

// File: rtl/i2c_sync.sv
`timescale 1ns/1ps
module i2c_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] ff_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff_q[s] <= '1;
            end else if (s == 0) begin
                ff_q[s] <= d;
            end else begin
                ff_q[s] <= ff_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl;
            sda_p_q <= sda;
        end
    end

    assign scl_rise  =  scl && !scl_p_q;
    assign scl_fall  = !scl &&  scl_p_q;
    assign start_det =  scl && scl_p_q && sda_p_q && !sda;
    assign stop_det  =  scl && scl_p_q && !sda_p_q && sda;
endmodule

// File: rtl/i2c_mem_store.sv
`timescale 1ns/1ps
module i2c_mem_store #(
    parameter int DEPTH = 96,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int         REG_BYTES = 32,
    parameter int         RAM_BYTES = 64,
    parameter logic [6:0] TARGET_ID = 7'b1101111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int MEM_BYTES = REG_BYTES + RAM_BYTES;

    function automatic logic in_map(input logic [BYTE_W-1:0] a);
        return int'(a) < MEM_BYTES;
    endfunction

    function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] a);
        if (int'(a) == REG_BYTES - 1) return '0;
        if (int'(a) == MEM_BYTES - 1) return BYTE_W'(REG_BYTES);
        return a + BYTE_W'(1);
    endfunction

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    i2c_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_s),
        .sda       (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tgt_state_t        st_d, st_q;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata;

    i2c_mem_store #(.DEPTH(MEM_BYTES), .AW(BYTE_W), .DW(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.ptr),
        .wdata (st_q.shreg),
        .raddr (st_q.ptr),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (start_det) begin
            st_d.phase = PH_RX;
            st_d.kind  = BK_CTRL;
            st_d.bits  = '0;
            st_d.oe    = 1'b0;
        end else if (stop_det) begin
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_RX: begin
                    if (scl_rise && st_q.bits != 4'd8) begin
                        st_d.shreg = {st_q.shreg[BYTE_W-2:0], sda_s};
                        st_d.bits  = st_q.bits + 4'd1;
                    end else if (scl_fall && st_q.bits == 4'd8) begin
                        st_d.bits  = '0;
                        st_d.phase = PH_ACK;
                        st_d.oe    = 1'b1;
                        st_d.go_tx = 1'b0;
                        unique case (st_q.kind)
                            BK_CTRL: begin
                                if (st_q.shreg[7:1] == TARGET_ID) begin
                                    if (st_q.shreg[0]) st_d.go_tx = 1'b1;
                                    else               st_d.kind  = BK_ADDR;
                                end else begin
                                    st_d.phase = PH_IDLE;
                                    st_d.oe    = 1'b0;
                                end
                            end
                            BK_ADDR: begin
                                if (in_map(st_q.shreg)) begin
                                    st_d.ptr  = st_q.shreg;
                                    st_d.kind = BK_DATA;
                                end else begin
                                    st_d.phase = PH_IDLE;
                                    st_d.oe    = 1'b0;
                                end
                            end
                            default: begin
                                mem_we   = 1'b1;
                                st_d.ptr = ptr_step(st_q.ptr);
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        st_d.bits = '0;
                        if (st_q.go_tx) begin
                            st_d.phase = PH_TX;
                            st_d.shreg = mem_rdata;
                            st_d.oe    = !mem_rdata[BYTE_W-1];
                        end else begin
                            st_d.phase = PH_RX;
                            st_d.oe    = 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (st_q.bits == 4'd7) begin
                            st_d.oe    = 1'b0;
                            st_d.phase = PH_MACK;
                            st_d.ptr   = ptr_step(st_q.ptr);
                        end else begin
                            st_d.shreg = {st_q.shreg[BYTE_W-2:0], 1'b0};
                            st_d.oe    = !st_q.shreg[BYTE_W-2];
                            st_d.bits  = st_q.bits + 4'd1;
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise) begin
                        st_d.more = !sda_s;
                    end else if (scl_fall) begin
                        if (st_q.more) begin
                            st_d.phase = PH_TX;
                            st_d.shreg = mem_rdata;
                            st_d.oe    = !mem_rdata[BYTE_W-1];
                            st_d.bits  = '0;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.oe;
endmodule

// File: rtl/i2c_mem_target_chk.sv
`timescale 1ns/1ps
module i2c_mem_target_chk #(
    parameter int MEM_BYTES = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       mem_we,
    input logic [7:0] ptr,
    input logic       idle,
    input logic       mack
);
    // R2: the pull-down only begins while the clock line is low
    a_r2_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R4: every stored byte is followed by an ACK
    a_r4_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sda_oe);

    // R9: the pointer never leaves the populated map
    a_r9_ptr_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < MEM_BYTES);

    // R1: no drive unless a transfer is in progress for this target
    a_r1_drive_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> !idle);

    // R7: the master's acknowledge slot is left free
    a_r7_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
        mack |-> !sda_oe);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (scl_s),
    .sda_oe (sda_oe_o),
    .mem_we (mem_we),
    .ptr    (st_q.ptr),
    .idle   (st_q.phase == i2c_mem_pkg::PH_IDLE),
    .mack   (st_q.phase == i2c_mem_pkg::PH_MACK)
);

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;
    localparam int CLK_P     = 10;
    localparam int Q         = 10 * CLK_P;
    localparam int REG_BYTES = 32;
    localparam int MEM_BYTES = 96;
    localparam int WD_LIMIT  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [MEM_BYTES];
    logic [7:0] ref_ptr = '0;

    i2c_mem_target i_i2c_mem_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] ref_step(input logic [7:0] a);
        if (int'(a) == REG_BYTES - 1) return 8'h00;
        if (int'(a) == MEM_BYTES - 1) return 8'(REG_BYTES);
        return a + 8'd1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R): actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b0; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #Q;
            scl = 1'b1;   #(2*Q);
            scl = 1'b0;   #Q;
        end
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        ack = (sda_line == 1'b0);
        #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q;
            scl = 1'b1; #Q;
            b[i] = sda_line;
            #Q;
            scl = 1'b0;
        end
        sda_m = !give_ack; #Q;
        scl = 1'b1; #(2*Q);
        scl = 1'b0;
        sda_m = 1'b1; #Q;
    endtask

    task automatic do_write(input logic [7:0] addr, input int n);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hDE, ack);
        check(ack, "R1 write control ack", ack, 1);
        send_byte(addr, ack);
        if (int'(addr) < MEM_BYTES) begin
            check(ack, "R3 address ack", ack, 1);
            ref_ptr = addr;
            for (int k = 0; k < n; k++) begin
                d = 8'($urandom);
                send_byte(d, ack);
                check(ack, "R4 data ack", ack, 1);
                ref_mem[ref_ptr] = d;
                ref_ptr = ref_step(ref_ptr);
            end
        end else begin
            check(!ack, "R9 unmapped address nack", ack, 0);
        end
        bus_stop();
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            check(b == ref_mem[ref_ptr], req, b, ref_mem[ref_ptr]);
            ref_ptr = ref_step(ref_ptr);
        end
        check(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic do_read_cur(input int n);
        bit ack;
        bus_start();
        send_byte(8'hDF, ack);
        check(ack, "R1 read control ack", ack, 1);
        read_body(n, "R5 current read data");
    endtask

    task automatic do_read_rand(input logic [7:0] addr, input int n);
        bit ack;
        bus_start();
        send_byte(8'hDE, ack);
        check(ack, "R1 write control ack", ack, 1);
        send_byte(addr, ack);
        if (int'(addr) >= MEM_BYTES) begin
            check(!ack, "R9 unmapped address nack", ack, 0);
            bus_stop();
            return;
        end
        check(ack, "R6 address ack", ack, 1);
        ref_ptr = addr;
        bus_start();
        send_byte(8'hDF, ack);
        check(ack, "R6 read control after repeated start", ack, 1);
        read_body(n, "R7 random/sequential read data");
    endtask

    initial begin
        bit ack;
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        #(5*CLK_P);
        rst_n = 1'b1;
        #Q;
        check(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);
        check(sda_oe == 1'b0, "R2 idle release", sda_oe, 0);

        do_write(8'h00, 32);
        do_write(8'h20, 64);
        check(ref_ptr == 8'h20, "R8 write wrap model", ref_ptr, 8'h20);
        do_read_cur(2);

        // R10: pointer returns to 0, storage kept
        rst_n = 1'b0; #(5*CLK_P); rst_n = 1'b1; #Q;
        ref_ptr = 8'h00;
        do_read_cur(1);

        // R1: foreign control code and the following byte are refused
        bus_start();
        send_byte(8'hA0, ack);
        check(!ack, "R1 foreign code nack", ack, 0);
        send_byte(8'h05, ack);
        check(!ack, "R1 ignored until start", ack, 0);
        bus_stop();
        do_read_cur(1);

        // R9: unmapped addresses leave pointer alone
        do_write(8'h60, 0);
        do_write(8'hFF, 0);
        do_read_cur(1);

        // R3: single write, pointer lands after it
        do_write(8'h44, 1);
        do_read_cur(1);
        do_read_rand(8'h44, 1);

        // R8: both windows wrap
        do_write(8'h1E, 3);
        do_read_rand(8'h1E, 4);
        do_read_rand(8'h5E, 3);
        do_write(8'h5F, 2);
        do_read_cur(2);

        // R6: address-only write sets up the next read
        do_write(8'h30, 0);
        do_read_cur(3);

        for (int op = 0; op < 25; op++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 111));
            case ($urandom_range(0, 2))
                0: do_write(a, $urandom_range(0, 4));
                1: do_read_cur($urandom_range(1, 4));
                default: do_read_rand(a, $urandom_range(1, 4));
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule